// File: doc/BRIEF.md
# Thread-Block Dispatcher

This block hands the thread blocks of one launched grid to a small pool of multiprocessor slots. A launch names how many blocks the grid has and how many threads each block holds. The dispatcher then issues blocks in ascending index order, at most one per clock. Each block goes to the lowest-numbered multiprocessor that still has room for it.

Every multiprocessor has two limits that apply together: a cap on resident blocks and a cap on resident threads. Threads are counted in whole warps of 32, so a partly filled warp costs a full one. When a multiprocessor reports that a block has finished, the block's resources are freed, and the next waiting block may take that space on the following clock. After every block has been issued and has finished, the dispatcher raises a one-cycle done pulse and returns to idle.

Top module: `grid_dispatch`

## Requirements
- R1: A launch with 0 threads or more than 512 threads per block is refused. `launch_err` reads 1 from the next cycle, nothing is issued, and the dispatcher stays idle. The next accepted launch clears `launch_err`.
- R2: No multiprocessor ever holds more than 8 resident blocks. With 32-thread blocks, each multiprocessor takes exactly 8 and then stalls.
- R3: Each block costs ceil(threads/32) warps. A multiprocessor accepts a block only if its resident warps plus the new block's warps do not exceed 24 (768 threads). So 512-thread blocks fit one per unit, 256-thread blocks fit three, and 100-thread blocks fit six.
- R4: Blocks are issued with indices 0, 1, 2, … up to the count minus 1, never skipping one. A block that fits nowhere stalls the whole sequence until room appears.
- R5: A block goes to the lowest-numbered multiprocessor with room for it. `disp_sm` carries that number as a binary value.
- R6: A valid completion pulse on lane s (`done_valid[s]`, with the block index in `done_id[s*8 +: 8]`) frees that block's warps and its block slot. A block waiting for that room is issued in the very next cycle.
- R7: `grid_done` is high for exactly one cycle, one cycle after the last resident block's completion is taken in. `busy` then falls.
- R8: A completion naming a block that is not resident on that lane sets the sticky `cpl_err` and frees nothing. Only reset clears `cpl_err`.
- R9: A launch request that arrives while a grid is in progress is ignored.
- R10: After reset, `busy`, `disp_valid`, `grid_done`, `launch_err` and `cpl_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request strobe |
| launch_blocks | input | 8 | Number of blocks in the grid |
| launch_threads | input | 11 | Threads per block |
| done_valid | input | 4 | Per-multiprocessor completion strobe |
| done_id | input | 32 | Per-lane finished block index, 8 bits per lane |
| disp_valid | output | 1 | A block is issued this cycle |
| disp_idx | output | 8 | Index of the issued block |
| disp_sm | output | 2 | Target multiprocessor |
| busy | output | 1 | A grid is in progress |
| grid_done | output | 1 | One-cycle grid completion pulse |
| launch_err | output | 1 | Last launch was refused |
| cpl_err | output | 1 | Sticky flag for a bad completion |

## Verification
A wrong resident count or warp total shows up at the ports in the first cycle the next block is weighed. The block goes to the wrong multiprocessor, goes out too early, or stalls. Stalled sequences therefore have the bench hold the pool full for several idle cycles before any completion. A lost or misplaced slot entry only shows later: either a legitimate completion raises `cpl_err`, or `grid_done` never comes. For that reason every scenario drains the grid and waits for the done pulse.

// File: rtl/grid_dispatch.sv
module grid_dispatch #(
  parameter int NUM_SM      = 4,
  parameter int MAX_BLK_SM  = 8,
  parameter int MAX_THR_SM  = 768,
  parameter int MAX_THR_BLK = 512,
  parameter int WARP        = 32,
  parameter int BW          = 8,
  parameter int TW          = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 launch_valid,
  input  logic [BW-1:0]        launch_blocks,
  input  logic [TW-1:0]        launch_threads,
  input  logic [NUM_SM-1:0]    done_valid,
  input  logic [NUM_SM*BW-1:0] done_id,
  output logic                 disp_valid,
  output logic [BW-1:0]        disp_idx,
  output logic [SW-1:0]        disp_sm,
  output logic                 busy,
  output logic                 grid_done,
  output logic                 launch_err,
  output logic                 cpl_err
);
  localparam int SW   = (NUM_SM > 1) ? $clog2(NUM_SM) : 1;
  localparam int WCAP = MAX_THR_SM / WARP;
  localparam int WW   = $clog2(WCAP + 1) + 1;
  localparam int CW   = $clog2(MAX_BLK_SM + 1);
  localparam int LW   = (MAX_BLK_SM > 1) ? $clog2(MAX_BLK_SM) : 1;

  logic            running;
  logic [BW-1:0]   total, next_idx;
  logic [WW-1:0]   wpb;
  logic [CW-1:0]   bcnt   [NUM_SM];
  logic [WW-1:0]   wcnt   [NUM_SM];
  logic [BW-1:0]   slot_id[NUM_SM][MAX_BLK_SM];
  logic [MAX_BLK_SM-1:0] slot_v [NUM_SM];

  logic [NUM_SM-1:0] fit, take, rel, bad;
  logic [LW-1:0]     free_slot[NUM_SM];
  logic [LW-1:0]     hit_slot [NUM_SM];
  logic              all_idle;
  logic [TW:0]       warps_req;

  assign busy      = running;
  assign warps_req = ({1'b0, launch_threads} + (TW+1)'(WARP - 1)) / (TW+1)'(WARP);

  always_comb begin
    all_idle = 1'b1;
    for (int s = 0; s < NUM_SM; s++) begin
      fit[s] = (bcnt[s] < CW'(MAX_BLK_SM)) && ((wcnt[s] + wpb) <= WW'(WCAP));
      if (bcnt[s] != '0) all_idle = 1'b0;
      free_slot[s] = '0;
      for (int k = MAX_BLK_SM - 1; k >= 0; k--)
        if (!slot_v[s][k]) free_slot[s] = LW'(k);
      hit_slot[s] = '0;
      rel[s] = 1'b0;
      for (int k = 0; k < MAX_BLK_SM; k++)
        if (slot_v[s][k] && slot_id[s][k] == done_id[s*BW +: BW] && !rel[s]) begin
          hit_slot[s] = LW'(k);
          rel[s] = done_valid[s];
        end
      bad[s] = done_valid[s] && !rel[s];
    end
    disp_sm = '0;
    for (int s = NUM_SM - 1; s >= 0; s--)
      if (fit[s]) disp_sm = SW'(s);
    disp_valid = running && (next_idx != total) && (|fit);
    disp_idx   = next_idx;
    take = '0;
    if (disp_valid) take[disp_sm] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; grid_done <= 1'b0; launch_err <= 1'b0; cpl_err <= 1'b0;
      total <= '0; next_idx <= '0; wpb <= '0;
      for (int s = 0; s < NUM_SM; s++) begin
        bcnt[s] <= '0; wcnt[s] <= '0; slot_v[s] <= '0;
        for (int k = 0; k < MAX_BLK_SM; k++) slot_id[s][k] <= '0;
      end
    end else begin
      grid_done <= 1'b0;
      if (|bad) cpl_err <= 1'b1;
      if (launch_valid && !running) begin
        if (launch_threads == '0 || launch_threads > TW'(MAX_THR_BLK)) begin
          launch_err <= 1'b1;
        end else begin
          launch_err <= 1'b0;
          running    <= 1'b1;
          total      <= launch_blocks;
          next_idx   <= '0;
          wpb        <= WW'(warps_req);
        end
      end else if (running && next_idx == total && all_idle) begin
        running   <= 1'b0;
        grid_done <= 1'b1;
      end
      if (disp_valid) next_idx <= next_idx + 1'b1;
      for (int s = 0; s < NUM_SM; s++) begin
        bcnt[s] <= bcnt[s] + CW'(take[s]) - CW'(rel[s]);
        wcnt[s] <= wcnt[s] + (take[s] ? wpb : '0) - (rel[s] ? wpb : '0);
        if (take[s]) begin
          slot_v[s][free_slot[s]]  <= 1'b1;
          slot_id[s][free_slot[s]] <= next_idx;
        end
        if (rel[s]) slot_v[s][hit_slot[s]] <= 1'b0;
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SM; g++) begin : g_chk
      p_blk_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt[g] <= CW'(MAX_BLK_SM));
      p_warp_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt[g] <= WW'(WCAP));
    end
  endgenerate

  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_valid && !running && launch_threads > TW'(MAX_THR_BLK)) |=> (launch_err && !busy));
  p_in_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && $past(disp_valid) && $past(running)) |-> (disp_idx == BW'($past(disp_idx) + 1'b1)));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |=> !grid_done);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_err |=> cpl_err);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grid_done |-> (!busy && !disp_valid));
endmodule

// File: tb/grid_dispatch_tb.sv
`timescale 1ns/1ps
module grid_dispatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        launch_valid = 1'b0;
  logic [7:0]  launch_blocks = '0;
  logic [10:0] launch_threads = '0;
  logic [3:0]  done_valid = '0;
  logic [31:0] done_id = '0;
  logic        disp_valid, busy, grid_done, launch_err, cpl_err;
  logic [7:0]  disp_idx;
  logic [1:0]  disp_sm;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];

  grid_dispatch u_dut (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_blocks(launch_blocks),
    .launch_threads(launch_threads), .done_valid(done_valid), .done_id(done_id),
    .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_sm(disp_sm), .busy(busy),
    .grid_done(grid_done), .launch_err(launch_err), .cpl_err(cpl_err));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int idx, input int sm);
    exp_q.push_back({idx[7:0], sm[1:0]});
  endtask

  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4/R2/R3 unexpected dispatch idx", int'(disp_idx), -1);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(disp_idx == e[9:2], "R4 dispatch index", int'(disp_idx), int'(e[9:2]));
        chk(disp_sm == e[1:0], "R5 target multiprocessor", int'(disp_sm), int'(e[1:0]));
      end
    end
  end

  task automatic launch(input int blocks, input int threads);
    @(posedge clk); #1;
    launch_valid = 1'b1; launch_blocks = blocks[7:0]; launch_threads = threads[10:0];
    @(posedge clk); #1;
    launch_valid = 1'b0;
  endtask

  task automatic cpl(input int sm, input int id);
    @(posedge clk); #1;
    done_valid[sm] = 1'b1; done_id[sm*8 +: 8] = id[7:0];
    @(posedge clk); #1;
    done_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic wait_done(input string req);
    int pulses = 0;
    repeat (8) begin
      @(negedge clk);
      if (grid_done) pulses++;
    end
    chk(pulses == 1, req, pulses, 1);
    chk(!busy, "R7 busy low after done", int'(busy), 0);
  endtask

  initial begin
    #(4 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    chk(!busy && !disp_valid && !grid_done && !launch_err && !cpl_err, "R10 reset state",
        {busy, disp_valid, grid_done, launch_err, cpl_err}, 0);
    rst_n = 1'b1;
    idle(2);

    // R1: oversize block refused, then empty block refused
    launch(4, 513);
    idle(5);
    chk(launch_err == 1'b1, "R1 launch_err after 513", int'(launch_err), 1);
    chk(!busy, "R1 stays idle", int'(busy), 0);
    launch(4, 0);
    idle(3);
    chk(launch_err == 1'b1, "R1 launch_err after 0 threads", int'(launch_err), 1);

    // R3 boundary: 512 threads is one block per multiprocessor
    for (int i = 0; i < 4; i++) push(i, i);
    launch(5, 512);
    idle(1);
    chk(launch_err == 1'b0, "R1 cleared by good launch", int'(launch_err), 0);
    idle(10);
    drained("R3 512-thread blocks one per unit");
    launch(50, 32);   // R9 ignored while busy
    idle(8);
    drained("R9 launch while busy ignored");
    push(4, 2);
    cpl(2, 2);
    @(negedge clk);
    chk(disp_valid && disp_idx == 8'd4, "R6 refill the next cycle", int'(disp_idx), 4);
    idle(4);
    drained("R6 block 4 on unit 2");
    cpl(0, 0); cpl(1, 1); cpl(3, 3); cpl(2, 4);
    wait_done("R7 done pulse grid 1");

    // R2: 32-thread blocks, block-count limit
    for (int i = 0; i < 32; i++) push(i, i / 8);
    launch(40, 32);
    idle(45);
    drained("R2 eight blocks per unit");
    cpl(1, 5);       // block 5 lives on unit 0
    idle(4);
    chk(cpl_err == 1'b1, "R8 bad completion flagged", int'(cpl_err), 1);
    drained("R8 bad completion frees nothing");
    for (int k = 0; k < 8; k++) begin
      push(32 + k, 2);
      cpl(2, 16 + k);
    end
    idle(3);
    drained("R5 freed room on unit 2 reused");
    for (int k = 0; k < 8; k++) begin
      cpl(0, k); cpl(1, 8 + k); cpl(2, 32 + k); cpl(3, 24 + k);
    end
    wait_done("R7 done pulse grid 2");
    chk(cpl_err == 1'b1, "R8 cpl_err sticky", int'(cpl_err), 1);

    // R3 rounding: 100 threads -> 4 warps -> six per unit
    for (int i = 0; i < 6; i++) push(i, 0);
    push(6, 1);
    launch(7, 100);
    idle(12);
    drained("R3 partial warp rounds up");
    for (int k = 0; k < 6; k++) cpl(0, k);
    cpl(1, 6);
    wait_done("R7 done pulse grid 3");

    // R3/R5/R6: 256 threads, three per unit, refill lowest
    for (int i = 0; i < 12; i++) push(i, i / 3);
    launch(14, 256);
    idle(20);
    drained("R3 three 256-thread blocks per unit");
    push(12, 1);
    cpl(1, 4);
    idle(2);
    push(13, 0);
    cpl(0, 0);
    idle(3);
    drained("R6 refill after completions");
    cpl(0, 1); cpl(0, 2); cpl(0, 13);
    cpl(1, 3); cpl(1, 5); cpl(1, 12);
    for (int k = 6; k < 12; k++) cpl(k / 3, k);
    wait_done("R7 done pulse grid 4");

    // R7: empty grid finishes at once
    launch(0, 64);
    wait_done("R7 empty grid");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule